// File: doc/BRIEF.md
# Lock-Gated Multi-Output Clock Divider

This block sits behind a phase-locked oscillator and turns its single high-speed clock into a small set of divided output clocks. Each output has its own divide ratio, from 1 to 63, and its own enable. All outputs stay silent after start-up until the oscillator reports lock for the first time. Once that first lock is seen, it is latched, and every enabled output runs until the oscillator itself is switched off.

The lock status arrives from analog circuitry, so it passes through a synchronizer before the first-lock latch samples it. Each output channel counts input cycles and produces a high phase of ceil(N/2) cycles followed by a low phase of floor(N/2) cycles. A ratio of 1 gates the input clock straight through. Changes to an output's enable or ratio are applied only at the end of that output's current period, so no runt pulse can appear. Dropping the oscillator enable forces every output low at once and clears the first-lock latch. A new lock is then needed before any output runs again.

Top module: `lock_gated_divider_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every output clock is low.
- R2: No output toggles before the first lock has been seen since the oscillator enable rose, even if its output enable is set.
- R3: For an enabled output with ratio N from 2 to 63, each output period is high for ceil(N/2) input cycles and then low for floor(N/2) input cycles.
- R4: An enabled output with ratio 1 follows the input clock: high while the input clock is high and low while it is low.
- R5: A ratio field of 0 is treated as ratio 1. Ratio fields are 6 bits each, and output i uses bits [6i+5:6i] of the ratio bus.
- R6: An output whose enable bit is clear stays low. Each output runs independently of the enables and ratios of the other outputs.
- R7: Clearing an output's enable or changing its ratio takes effect only at the end of the current output period. The high phase in progress completes at its full length.
- R8: Once the first lock has been seen, a later drop of the lock input does not stop or alter any output.
- R9: Clearing the oscillator enable drives every output low within one input cycle and clears the first-lock latch. After the enable rises again, outputs stay low until lock is reported again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | High-speed input clock from the oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | Oscillator enable; low forces outputs low and clears the lock latch |
| lock_raw | input | 1 | Asynchronous lock status from the oscillator |
| ratio_bus | input | 24 | Four 6-bit divide ratios, output i at bits [6i+5:6i] |
| out_en | input | 4 | Per-output enable, bit i for output i |
| clk_out | output | 4 | Divided output clocks, bit i for output i |

## Verification
The hardest situation to reach from the ports is a change that arrives in the middle of an output period. The bench has to show that the high phase in progress still completes at its full length, and that the new enable or ratio only appears in the period after it. To get there, the bench watches a running output, catches its rising edge, and then applies the disable or ratio change one cycle later, well inside the high phase. It then measures the length of the high run and the runs that follow. A second hard case is re-enabling the oscillator while lock is still low. The bench reaches it by dropping lock after the first lock, toggling the oscillator enable, and confirming that the outputs stay silent until lock rises again.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Ratio actually used by a channel: zero is promoted to one.
  function automatic int eff_ratio(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Number of input cycles the output stays high within one period.
  function automatic int high_len(input int n);
    return (eff_ratio(n) + 1) / 2;
  endfunction

  // Number of input cycles the output stays low within one period.
  function automatic int low_len(input int n);
    return eff_ratio(n) / 2;
  endfunction

endpackage

// File: rtl/first_lock_latch.sv
module first_lock_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic lock_raw,
  output logic lock_seen
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lock_sync;

  assign lock_sync = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= lock_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_raw};
      end
    end
  endgenerate

  // Sticky first-lock flag, cleared only by the oscillator enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_seen <= 1'b0;
    else if (!osc_en) lock_seen <= 1'b0;
    else if (lock_sync) lock_seen <= 1'b1;
  end

  // R8: once latched, the flag survives a lock drop while enabled.
  assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_seen && osc_en) |=> lock_seen);

  // R9: disabling the oscillator clears the latch.
  assert_latch_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !lock_seen);

  // R2: the latch only sets from a synchronized lock report.
  assert_latch_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_seen) |-> $past(lock_sync));

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               lock_ok,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               clk_out
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cur_ratio_q;
  logic [RATIO_W-1:0] ratio_eff;
  logic               active_q;
  logic               level_q;
  logic               bypass_q;
  logic               gate_ok;
  logic               period_end;

  assign ratio_eff  = RATIO_W'(eff_ratio(int'(ratio_in)));
  assign gate_ok    = osc_en && lock_ok && en;
  assign period_end = !active_q || (int'(cnt_q) == int'(cur_ratio_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cur_ratio_q <= RATIO_W'(1);
      active_q    <= 1'b0;
      level_q     <= 1'b0;
    end else if (!osc_en) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      level_q  <= 1'b0;
    end else if (period_end) begin
      cnt_q       <= '0;
      cur_ratio_q <= ratio_eff;
      active_q    <= gate_ok;
      level_q     <= gate_ok && (int'(ratio_eff) != 1);
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      level_q <= (int'(cnt_q) + 1) < high_len(int'(cur_ratio_q));
    end
  end

  // Ratio-1 gate changes while the input clock is low, so the AND is clean.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bypass_q <= 1'b0;
    else        bypass_q <= active_q && (int'(cur_ratio_q) == 1);
  end

  assign clk_out = level_q | (clk & bypass_q);

  // R2: without the lock flag the divided level never rises.
  assert_no_out_without_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_ok && !active_q) |=> !level_q);

  // R3: the counter never leaves the current period.
  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < cur_ratio_q));

  // R7: ratio only reloads at a period end.
  assert_ratio_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(cur_ratio_q));

  // R7: an enable drop cannot stop a period in progress.
  assert_enable_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !period_end && osc_en) |=> active_q);

  // R9: oscillator disable forces the channel off at the next edge.
  assert_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!active_q && !level_q));

endmodule

// File: rtl/lock_gated_divider_bank.sv
module lock_gated_divider_bank #(
  parameter int NUM_OUT     = 4,
  parameter int RATIO_W     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = NUM_OUT * RATIO_W
) (
  input  logic               clk_vco,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               lock_raw,
  input  logic [BUS_W-1:0]   ratio_bus,
  input  logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] clk_out
);

  logic lock_seen;

  first_lock_latch #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_lock (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .lock_raw (lock_raw),
    .lock_seen(lock_seen)
  );

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
      clkdiv_channel #(
        .RATIO_W(RATIO_W)
      ) u_ch (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .lock_ok (lock_seen),
        .en      (out_en[i]),
        .ratio_in(ratio_bus[i*RATIO_W +: RATIO_W]),
        .clk_out (clk_out[i])
      );
    end
  endgenerate

endmodule

// File: tb/tb_lock_gated_divider_bank.sv
`timescale 1ns/1ps
module tb_lock_gated_divider_bank;

  localparam int NO = 4;
  localparam int RW = 6;

  logic          clk_vco = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_en = 1'b0;
  logic          lock_raw = 1'b0;
  logic [NO*RW-1:0] ratio_bus = '0;
  logic [NO-1:0] out_en = '0;
  logic [NO-1:0] clk_out;

  int errors = 0;
  int checks = 0;
  int ch1_ones = 0;
  bit done = 0;

  lock_gated_divider_bank dut (
    .clk_vco(clk_vco), .rst_n(rst_n), .osc_en(osc_en), .lock_raw(lock_raw),
    .ratio_bus(ratio_bus), .out_en(out_en), .clk_out(clk_out)
  );

  always #5 clk_vco = ~clk_vco;

  // Vector table: ratio, expected high run, expected low run (0/0 = bypass)
  typedef struct packed { logic [7:0] ratio; logic [7:0] hi; logic [7:0] lo; } vec_t;
  localparam vec_t VECS [7] = '{
    '{8'd2, 8'd1, 8'd1}, '{8'd3, 8'd2, 8'd1}, '{8'd7, 8'd4, 8'd3},
    '{8'd8, 8'd4, 8'd4}, '{8'd63, 8'd32, 8'd31}, '{8'd1, 8'd0, 8'd0},
    '{8'd0, 8'd0, 8'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance to 2 ns after the next rising edge (input clock high).
  task automatic tick();
    @(posedge clk_vco);
    #2;
    if (clk_out[1]) ch1_ones++;
  endtask

  task automatic set_ratio(input int ch, input int r);
    ratio_bus[ch*RW +: RW] = RW'(r);
  endtask

  // Count a run of the given level on output ch, starting at current sample.
  task automatic run_len(input int ch, input bit lvl, output int n);
    n = 0;
    while (clk_out[ch] == lvl && n < 200) begin
      n++;
      tick();
    end
  endtask

  task automatic wait_level(input int ch, input bit lvl);
    for (int k = 0; k < 200 && clk_out[ch] != lvl; k++) tick();
  endtask

  task automatic measure(input int ch, input string tag, input int hi, input int lo);
    int h, l;
    wait_level(ch, 1'b0);
    wait_level(ch, 1'b1);
    run_len(ch, 1'b1, h);
    run_len(ch, 1'b0, l);
    chk(h == hi, {tag, " high run"}, h, hi);
    chk(l == lo, {tag, " low run"}, l, lo);
  endtask

  task automatic check_bypass(input int ch, input string tag);
    int bad = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (clk_out[ch] !== 1'b1) bad++;
      #5;
      if (clk_out[ch] !== 1'b0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic check_silent(input int cycles, input string tag);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (clk_out !== '0) bad++;
      #5;
      if (clk_out !== '0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_vco);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h;
    // R1: reset state
    repeat (3) tick();
    chk(clk_out == '0, "R1 outputs low in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    tick();
    chk(clk_out == '0, "R1 outputs low after reset", int'(clk_out), 0);

    // R2: everything enabled, no lock yet
    set_ratio(0, 4); set_ratio(1, 5); set_ratio(2, 5); set_ratio(3, 0);
    out_en = 4'b1101;
    osc_en = 1'b1;
    check_silent(40, "R2 silent before first lock");

    lock_raw = 1'b1;
    repeat (10) tick();
    ch1_ones = 0;

    // R3 R4 R5: walk the vector table on output 0
    foreach (VECS[i]) begin
      set_ratio(0, int'(VECS[i].ratio));
      repeat (140) tick();
      if (VECS[i].hi == 0)
        check_bypass(0, $sformatf("R4 R5 bypass ratio %0d", VECS[i].ratio));
      else
        measure(0, $sformatf("R3 ratio %0d", VECS[i].ratio), int'(VECS[i].hi), int'(VECS[i].lo));
    end

    // R5: output 3 has ratio field 0 and must act as ratio 1
    check_bypass(3, "R5 zero ratio on output 3");
    // R6: output 1 disabled all along, output 2 independent
    chk(ch1_ones == 0, "R6 disabled output 1 stayed low", ch1_ones, 0);
    measure(2, "R6 output 2 ratio 5", 3, 2);

    // R8: drop lock after first lock; outputs keep running
    lock_raw = 1'b0;
    repeat (10) tick();
    measure(2, "R8 output 2 after lock drop", 3, 2);

    // R7: enable drop mid high phase
    set_ratio(0, 8);
    repeat (140) tick();
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    tick();
    out_en[0] = 1'b0;
    run_len(0, 1'b1, h);
    chk(h + 1 == 4, "R7 high phase completes after disable", h + 1, 4);
    begin
      int ones = 0;
      for (int k = 0; k < 40; k++) begin tick(); if (clk_out[0]) ones++; end
      chk(ones == 0, "R7 output low after disable", ones, 0);
    end

    // R7: ratio change mid high phase
    out_en[0] = 1'b1;
    wait_level(0, 1'b1);
    tick();
    set_ratio(0, 2);
    run_len(0, 1'b1, h);
    chk(h + 1 == 4, "R7 old ratio high phase completes", h + 1, 4);
    run_len(0, 1'b0, h);
    chk(h == 4, "R7 old ratio low phase completes", h, 4);
    measure(0, "R7 new ratio 2 applied", 1, 1);

    // R9: oscillator disable, then re-enable with lock still low
    osc_en = 1'b0;
    tick();
    check_silent(20, "R9 outputs low after disable");
    osc_en = 1'b1;
    check_silent(30, "R9 silent until new lock");
    lock_raw = 1'b1;
    repeat (6) tick();
    measure(2, "R9 output 2 resumes after new lock", 3, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule